// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store command into a stream of per-element memory word addresses. A command latches a base address, a mode, a stride and an element count. The block then emits one address per clock cycle, and each address carries the number of the interleaved memory bank it falls in and the index of its element within the vector. The modes are contiguous (step of one word), constant stride (any step, with wrap-around), and indexed. In indexed mode each address is the base plus an offset taken from an incoming index stream. Gathers and scatters use indexed mode in the same way, so the block does not need to know the transfer direction.

The memory is made of a power-of-two number of banks, and each bank stays occupied for a fixed number of cycles after it is accessed. The block keeps a busy counter for every bank. When the next element targets a bank that is still occupied, the address stream stalls and the element index holds until the bank frees. This exposes the throughput loss caused by strides that fold onto few banks. A one-cycle completion pulse follows the last address.

Top module: `vec_addr_gen`

## Requirements
- R1: In contiguous mode (mode 0), element i has address base + i.
- R2: In constant-stride mode (mode 1), element i has address base + i*stride, computed modulo 2^32, so a stride of all ones walks downward.
- R3: In indexed mode (mode 2), each address is base + idx_data. An address is issued only while idx_valid is 1, and idx_ready is 1 in exactly the cycles that consume an index element (it is 0 in the other modes).
- R4: addr_bank equals the low 4 bits of addr, which is the word address modulo the 16 banks.
- R5: busy rises in the cycle after an accepted start. The first address can appear in that same cycle, and when no bank conflict or index gap exists, addresses follow on consecutive cycles.
- R6: After a bank is accessed in cycle t, no address targets that bank before cycle t+4. A stalled element keeps its address and index until its bank frees, which also applies across commands.
- R7: The element count is vlen clamped to 64. Elements are issued in order with addr_elem running from 0 to count-1.
- R8: done is 1 for exactly one cycle, namely the cycle after the last address, and busy is 0 in that cycle. With a count of zero, done is 1 in the cycle after start and no address is issued.
- R9: A start asserted while busy is 1 is ignored, and the running command's addresses are unchanged.
- R10: Mode 3 behaves as contiguous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 contiguous |
| base | input | 32 | Base word address |
| stride | input | 32 | Word step for strided mode |
| vlen | input | 8 | Requested element count, clamped to 64 |
| idx_valid | input | 1 | Index stream element present |
| idx_data | input | 32 | Index stream word offset |
| idx_ready | output | 1 | Index element consumed this cycle |
| addr_valid | output | 1 | Address issued this cycle |
| addr | output | 32 | Issued word address |
| addr_bank | output | 4 | Bank of the issued address |
| addr_elem | output | 6 | Element index of the issued address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step or base register shows at once, because the very next addr value is wrong. A bank counter that loads the wrong value or drops its count shows as an addr_valid arriving earlier or later than the arithmetic bank timeline predicts. Under a stride that folds onto one bank this appears within four cycles. An element counter that slips shows as a wrong addr_elem, a wrong total number of addresses, or a done pulse in the wrong cycle. The bench rebuilds the expected address and issue cycle of every element from the mode, the stride, the index values and the per-bank free times, and compares them cycle by cycle.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW     = 32,
  parameter int NBANK  = 16,
  parameter int LAT    = 4,
  parameter int MAX_VL = 64,
  parameter int VLW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  mode,
  input  logic [AW-1:0]               base,
  input  logic [AW-1:0]               stride,
  input  logic [VLW-1:0]              vlen,
  input  logic                        idx_valid,
  input  logic [AW-1:0]               idx_data,
  output logic                        idx_ready,
  output logic                        addr_valid,
  output logic [AW-1:0]               addr,
  output logic [$clog2(NBANK)-1:0]    addr_bank,
  output logic [$clog2(MAX_VL)-1:0]   addr_elem,
  output logic                        busy,
  output logic                        done
);
  localparam int BW = $clog2(NBANK);
  localparam int EW = $clog2(MAX_VL);
  localparam int NW = $clog2(MAX_VL + 1);
  localparam int CW = $clog2(LAT + 1);

  logic          busy_q, done_q, idx_mode_q;
  logic [AW-1:0] base_q, step_q, acc_q;
  logic [NW-1:0] elem_q, total_q, req_len;
  logic [CW-1:0] bank_cnt [NBANK];
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_bank;
  logic          issue, last;

  assign req_len  = (vlen > VLW'(MAX_VL)) ? NW'(MAX_VL) : NW'(vlen);
  assign cur_addr = idx_mode_q ? base_q + idx_data : acc_q;
  assign cur_bank = cur_addr[BW-1:0];
  assign issue    = busy_q && (bank_cnt[cur_bank] == '0) && (!idx_mode_q || idx_valid);
  assign last     = (elem_q == total_q - NW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      idx_mode_q <= 1'b0;
      base_q     <= '0;
      step_q     <= '0;
      acc_q      <= '0;
      elem_q     <= '0;
      total_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          base_q     <= base;
          acc_q      <= base;
          step_q     <= (mode == 2'd1) ? stride : AW'(1);
          idx_mode_q <= (mode == 2'd2);
          elem_q     <= '0;
          total_q    <= req_len;
          busy_q     <= (req_len != '0);
          done_q     <= (req_len == '0);
        end
      end else if (issue) begin
        elem_q <= elem_q + NW'(1);
        acc_q  <= acc_q + step_q;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_cnt[b] <= '0;
      else if (issue && cur_bank == BW'(b))
        bank_cnt[b] <= CW'(LAT - 1);
      else if (bank_cnt[b] != '0)
        bank_cnt[b] <= bank_cnt[b] - CW'(1);
    end
  end

  assign addr_valid = issue;
  assign idx_ready  = issue && idx_mode_q;
  assign addr       = cur_addr;
  assign addr_bank  = cur_bank;
  assign addr_elem  = elem_q[EW-1:0];
  assign busy       = busy_q;
  assign done       = done_q;
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int NBANK  = 16,
  parameter int LAT    = 4,
  parameter int MAX_VL = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      done,
  input logic                      addr_valid,
  input logic [$clog2(NBANK)-1:0]  addr_bank,
  input logic [$clog2(MAX_VL)-1:0] addr_elem,
  input logic                      idx_valid,
  input logic                      idx_ready
);
  localparam int BW = $clog2(NBANK);
  localparam int AGW = $clog2(LAT + 1);
  localparam int NW = $clog2(MAX_VL + 1);

  logic [AGW-1:0] age [NBANK];
  logic [NW-1:0]  issued;

  for (genvar b = 0; b < NBANK; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)
        age[b] <= AGW'(LAT);
      else if (addr_valid && addr_bank == BW'(b))
        age[b] <= AGW'(1);
      else if (age[b] < AGW'(LAT))
        age[b] <= age[b] + AGW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          issued <= '0;
    else if (done)       issued <= '0;
    else if (addr_valid) issued <= issued + NW'(1);
  end

  assert_bank_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> age[addr_bank] >= AGW'(LAT));
  assert_elem_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> NW'(addr_elem) == issued);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !addr_valid));
  assert_idx_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> (addr_valid && idx_valid));
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !addr_valid) |=> busy);
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.NBANK(NBANK), .LAT(LAT), .MAX_VL(MAX_VL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .addr_valid(addr_valid),
  .addr_bank(addr_bank), .addr_elem(addr_elem), .idx_valid(idx_valid), .idx_ready(idx_ready)
);

// File: tb/vec_addr_gen_bench.sv
module vec_addr_gen_bench;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [31:0] base = '0, stride = '0, idx_data = '0;
  logic [7:0]  vlen = '0;
  logic        idx_valid = 1'b0;
  logic        idx_ready, addr_valid, busy, done;
  logic [31:0] addr;
  logic [3:0]  addr_bank;
  logic [5:0]  addr_elem;

  int cyc = 0;
  int total = 0;
  int fails = 0;
  int bank_free [16];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_addr_gen u_vec_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base), .stride(stride),
    .vlen(vlen), .idx_valid(idx_valid), .idx_data(idx_data), .idx_ready(idx_ready),
    .addr_valid(addr_valid), .addr(addr), .addr_bank(addr_bank), .addr_elem(addr_elem),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic bit avail(input int c, input bit gap);
    return !(gap && (c % 3 == 0));
  endfunction

  function automatic logic [31:0] idx_of(input int kind, input int i);
    case (kind)
      0: return 32'(i * 5 + (i % 3) * 16);
      1: return 32'(i * 16);
      default: return 32'(63 - i);
    endcase
  endfunction

  task automatic run(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                     input int vl, input int ik, input bit gap, input bit restart, input string rq);
    int n, c0, t, prev, k, tl;
    logic [31:0] ea [64];
    int et [64];
    logic [31:0] ix [64];
    logic [31:0] a;
    n = (vl > 64) ? 64 : vl;
    @(negedge clk);
    start = 1'b1; mode = m; base = b; stride = s; vlen = 8'(vl);
    #1;
    c0 = cyc;
    check(busy == 1'b0, {rq, " idle before start"}, 64'(busy), 0);
    prev = c0;
    for (int i = 0; i < n; i++) begin
      ix[i] = idx_of(ik, i);
      if (m == 2'd1)      a = b + 32'(i) * s;
      else if (m == 2'd2) a = b + ix[i];
      else                a = b + 32'(i);
      t = (prev + 1 > bank_free[a[3:0]]) ? prev + 1 : bank_free[a[3:0]];
      if (m == 2'd2) while (!avail(t, gap)) t++;
      bank_free[a[3:0]] = t + LAT;
      ea[i] = a; et[i] = t; prev = t;
    end
    k = 0;
    tl = c0;
    for (int w = 0; w < 3000 && k < n; w++) begin
      @(negedge clk);
      if (restart && cyc == c0 + 2) begin
        start = 1'b1; mode = 2'd0; base = 32'h5555; vlen = 8'd3;
      end else start = 1'b0;
      idx_valid = avail(cyc, gap);
      idx_data = ix[k];
      #1;
      if (cyc == c0 + 1) check(busy == 1'b1, {rq, " R5 busy after start"}, 64'(busy), 1);
      if (addr_valid) begin
        check(cyc == et[k], {rq, " R5/R6 issue cycle"}, 64'(cyc), 64'(et[k]));
        check(addr == ea[k], {rq, " address"}, 64'(addr), 64'(ea[k]));
        check(addr_bank == ea[k][3:0], {rq, " R4 bank"}, 64'(addr_bank), 64'(ea[k][3:0]));
        check(addr_elem == 6'(k), {rq, " R7 element"}, 64'(addr_elem), 64'(k));
        check(idx_ready == (m == 2'd2), {rq, " R3 idx_ready"}, 64'(idx_ready), 64'(m == 2'd2));
        k++;
        tl = cyc;
      end
    end
    check(k == n, {rq, " R7 address count"}, 64'(k), 64'(n));
    @(negedge clk);
    start = 1'b0;
    #1;
    check(cyc == tl + 1 && done && !busy && !addr_valid, {rq, " R8 done pulse"},
          {32'(cyc), 31'd0, done}, {32'(tl + 1), 32'd1});
    @(negedge clk);
    #1;
    check(!done && !addr_valid, {rq, " R8 done single cycle"}, 64'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    foreach (bank_free[i]) bank_free[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !addr_valid, "reset state", {61'd0, busy, done, addr_valid}, 0);
    rst_n = 1'b1;
    run(2'd0, 32'd100, 32'd0, 20, 0, 0, 0, "R1 contiguous");
    run(2'd1, 32'd7, 32'd3, 16, 0, 0, 0, "R2 stride3");
    run(2'd1, 32'd64, 32'd32, 8, 0, 0, 1, "R6 R9 stride32 restart");
    run(2'd1, 32'd1, 32'd2, 16, 0, 0, 0, "R2 stride2");
    run(2'd1, 32'd3, 32'd8, 12, 0, 0, 0, "R6 stride8");
    run(2'd1, 32'd1000, 32'hFFFF_FFFF, 10, 0, 0, 0, "R2 negative stride");
    run(2'd2, 32'd40, 32'd0, 24, 0, 1, 0, "R3 indexed gaps");
    run(2'd2, 32'd5, 32'd0, 6, 1, 0, 0, "R3 R6 indexed same bank");
    run(2'd2, 32'd0, 32'd0, 64, 2, 0, 0, "R3 indexed reverse");
    run(2'd0, 32'd200, 32'd0, 0, 0, 0, 0, "R8 zero length");
    run(2'd0, 32'd300, 32'd0, 100, 0, 0, 0, "R7 clamp");
    run(2'd3, 32'd50, 32'd9, 10, 0, 0, 0, "R10 mode3");
    run(2'd1, 32'd0, 32'd16, 5, 0, 0, 0, "R6 stride16 back to back");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule